// File: doc/BRIEF.md
# Three-Byte Write Target with Tri-State Address Select

This block is a receive-only I2C target. It watches already-synchronized SCL and SDA levels and pulls SDA low through an open-drain output when it acknowledges. Its 7-bit address comes from two select inputs. Each select input reports one of three pin states: low, high or floating. Together they pick one of nine addresses. The block also answers a fixed broadcast address, whatever the select inputs say.

A transfer that the block accepts is a write of exactly three data bytes. The block acknowledges each of the three bytes. After the third acknowledge clock ends, it raises a one-cycle strobe that carries the 24-bit word. The block never acknowledges a read. It refuses any byte beyond the third, and it drops a partial word when a STOP arrives early.

Top module: `tri_addr_wr3_target`

## Requirements
- R1: While reset is asserted, `sda_pull_o` is 0, `word_valid_o` is 0 and `word_o` is 0.
- R2: Each select code means low (2'b00), high (2'b01) or floating (2'b10 or 2'b11). With index = 3*sel1 + sel0, where low=0, high=1 and float=2, the target address is 0x10, 0x11, 0x12, 0x13, 0x20, 0x21, 0x22, 0x23 or 0x30 for index 0 through 8.
- R3: Address 0x73 is acknowledged for every setting of the select inputs.
- R4: When the first byte after a START holds a matching address with R/W (bit 0) = 0, `sda_pull_o` is 1 while SCL is high on the ninth clock.
- R5: A first byte that holds a matching address with R/W = 1 is not acknowledged, and no later byte in that transfer is acknowledged.
- R6: A first byte with a non-matching address is not acknowledged, later bytes are not acknowledged, and no strobe results.
- R7: Data is sampled on the SCL rising edge, most significant bit first. Each of the three data bytes is acknowledged. One cycle after the SCL falling edge that ends the third acknowledge, `word_valid_o` is high for exactly one cycle. At that point `word_o` holds byte 1 in [23:16], byte 2 in [15:8] and byte 3 in [7:0], and it keeps that value afterwards.
- R8: Any data byte past the third in the same transfer is not acknowledged and produces no further strobe.
- R9: A STOP before the third data byte completes discards the partial word, and no strobe follows.
- R10: A repeated START clears the bit and byte counts. The transfer that follows it is decoded from its own address byte, and its own three bytes form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sel0_i | input | 2 | Select input 0 state (00 low, 01 high, 1x float) |
| sel1_i | input | 2 | Select input 1 state (00 low, 01 high, 1x float) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| word_valid_o | output | 1 | One-cycle strobe for a completed word |
| word_o | output | 24 | Last completed 24-bit word |

## Verification
A bit counter that is off by one moves the acknowledge pull into a data bit slot. This shows up at the very next ninth clock, either as a missing acknowledge or as SDA corrupted by the target. A wrong byte count shows up at the third acknowledge: the strobe is missing, comes early, or repeats on a fourth byte. A state that fails to leave the address phase, or a missed START or STOP, appears in the next transfer as a refused address or a stale word.

// File: rtl/tri_addr_wr3_target.sv
module tri_addr_wr3_target #(
  parameter logic [6:0] BCAST_ADDR = 7'h73,
  parameter int NBYTES = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [1:0]            sel0_i,
  input  logic [1:0]            sel1_i,
  output logic                  sda_pull_o,
  output logic                  word_valid_o,
  output logic [8*NBYTES-1:0]   word_o
);
  localparam int WW = 8 * NBYTES;
  localparam int NBW = $clog2(NBYTES + 1);
  localparam logic [NBW-1:0] NB_L = NBW'(NBYTES);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_SKIP} st_t;

  st_t            st;
  logic           scl_q, sda_q;
  logic [3:0]     bcnt;
  logic [NBW-1:0] nbyte;
  logic [7:0]     sh;
  logic [WW-1:0]  acc;

  function automatic logic [3:0] tri_val(input logic [1:0] c);
    return c[1] ? 4'd2 : (c[0] ? 4'd1 : 4'd0);
  endfunction

  logic [3:0] idx;
  logic [1:0] hi_bits;
  logic [6:0] my_addr;
  assign idx     = tri_val(sel1_i) * 4'd3 + tri_val(sel0_i);
  assign hi_bits = idx[3:2] + 2'd1;
  assign my_addr = {1'b0, hi_bits, 2'b00, idx[1:0]};

  wire start_c  = scl_q & scl_i & sda_q & ~sda_i;
  wire stop_c   = scl_q & scl_i & ~sda_q & sda_i;
  wire rise     = ~scl_q & scl_i;
  wire fall     = scl_q & ~scl_i;
  wire addr_hit = ~sh[0] & ((sh[7:1] == my_addr) | (sh[7:1] == BCAST_ADDR));
  wire room     = nbyte < NB_L;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      bcnt <= '0;
      nbyte <= '0;
      sh <= '0;
      acc <= '0;
      sda_pull_o <= 1'b0;
      word_valid_o <= 1'b0;
      word_o <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      word_valid_o <= 1'b0;
      if (start_c) begin
        st <= S_ADDR;
        bcnt <= '0;
        nbyte <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE;
        bcnt <= '0;
        sda_pull_o <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (bcnt < 4'd8) begin
            sh <= {sh[6:0], sda_i};
            bcnt <= bcnt + 4'd1;
          end else begin
            bcnt <= 4'd9;
          end
        end else if (fall) begin
          if (bcnt == 4'd8) begin
            if (st == S_ADDR) begin
              sda_pull_o <= addr_hit;
            end else if (st == S_DATA && room) begin
              sda_pull_o <= 1'b1;
              acc <= {acc[WW-9:0], sh};
            end
          end else if (bcnt == 4'd9) begin
            sda_pull_o <= 1'b0;
            bcnt <= '0;
            if (st == S_ADDR) begin
              st <= addr_hit ? S_DATA : S_SKIP;
            end else if (st == S_DATA && room) begin
              nbyte <= nbyte + 1'b1;
              if (nbyte == NB_L - 1'b1) begin
                word_valid_o <= 1'b1;
                word_o <= acc;
              end
            end
          end
        end
      end
    end
  end

  a_r4_pull_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_q);

  a_r7_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |=> !word_valid_o);

  a_r8_strobe_at_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o |-> (st == S_DATA && nbyte == NB_L));

  a_r5_no_pull_when_skipping: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP || st == S_IDLE) |-> !sda_pull_o);

  a_r9_stop_clears_pull: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_pull_o && !word_valid_o);
endmodule

// File: tb/sim_tri_addr_wr3_target.sv
module sim_tri_addr_wr3_target;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] sel0 = 2'b00, sel1 = 2'b00;
  logic sda_pull, wvalid;
  logic [23:0] word;
  wire sda_line = sda_m & ~sda_pull;

  always #2 clk = ~clk;

  tri_addr_wr3_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sel0_i(sel0), .sel1_i(sel1), .sda_pull_o(sda_pull),
    .word_valid_o(wvalid), .word_o(word));

  int checks = 0, fails = 0, strobes = 0, wide = 0;
  logic [23:0] last_word = '0;
  logic prev_v = 1'b0;
  bit done = 0;

  always @(posedge clk) begin
    prev_v <= wvalid;
    if (wvalid) begin strobes <= strobes + 1; last_word <= word; end
    if (wvalid && prev_v) wide <= wide + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (4) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; q(); scl = 1'b1; q(); sda_m = 1'b0; q(); scl = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl = 1'b1; q(); scl = 1'b0;
    end
    sda_m = 1'b1; q(); scl = 1'b1;
    repeat (2) @(negedge clk);
    acked = sda_pull;
    repeat (2) @(negedge clk);
    scl = 1'b0; q();
  endtask

  // {sel1, sel0, addr7, rw, data24, exp_ack}
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {2'b00, 2'b00, 7'h10, 1'b0, 24'hA53C0F, 1'b1},
    {2'b00, 2'b01, 7'h11, 1'b0, 24'h123456, 1'b1},
    {2'b00, 2'b10, 7'h12, 1'b0, 24'hFFFFFF, 1'b1},
    {2'b01, 2'b00, 7'h13, 1'b0, 24'h000000, 1'b1},
    {2'b01, 2'b01, 7'h20, 1'b0, 24'h80_01_7E, 1'b1},
    {2'b01, 2'b10, 7'h21, 1'b0, 24'h55AA55, 1'b1},
    {2'b10, 2'b00, 7'h22, 1'b0, 24'hC3_3C_99, 1'b1},
    {2'b10, 2'b01, 7'h23, 1'b0, 24'h0F_F0_01, 1'b1},
    {2'b10, 2'b10, 7'h30, 1'b0, 24'hDEAD42, 1'b1},
    {2'b11, 2'b11, 7'h30, 1'b0, 24'h7654_32, 1'b1},
    {2'b01, 2'b01, 7'h73, 1'b0, 24'hBEEF01, 1'b1},
    {2'b00, 2'b00, 7'h11, 1'b0, 24'h111111, 1'b0},
    {2'b00, 2'b00, 7'h10, 1'b1, 24'h222222, 1'b0},
    {2'b10, 2'b10, 7'h10, 1'b0, 24'h333333, 1'b0}
  };

  initial begin
    logic a;
    int s0;
    repeat (3) @(negedge clk);
    chk("R1 pull in reset", {31'd0, sda_pull}, 32'd0);
    chk("R1 valid in reset", {31'd0, wvalid}, 32'd0);
    chk("R1 word in reset", {8'd0, word}, 32'd0);
    rst_n = 1'b1; q();

    for (int v = 0; v < NV; v++) begin
      logic [36:0] e;
      e = VEC[v];
      sel1 = e[36:35]; sel0 = e[34:33]; q();
      s0 = strobes;
      i2c_start();
      send_byte({e[32:26], e[25]}, a);
      chk($sformatf("R2/R3/R4/R5/R6 addr ack vec %0d", v), {31'd0, a}, {31'd0, e[0]});
      for (int k = 0; k < 3; k++) begin
        logic [7:0] d;
        d = e[24 - 8*k -: 8];
        send_byte(d, a);
        chk($sformatf("R7/R6 data ack vec %0d byte %0d", v, k), {31'd0, a}, {31'd0, e[0]});
      end
      i2c_stop(); q();
      chk($sformatf("R7/R6 strobe count vec %0d", v), strobes - s0, e[0] ? 32'd1 : 32'd0);
      if (e[0]) chk($sformatf("R7 word vec %0d", v), {8'd0, last_word}, {8'd0, e[24:1]});
    end

    sel1 = 2'b00; sel0 = 2'b00; q();
    s0 = strobes;
    i2c_start();
    send_byte(8'h20, a);
    send_byte(8'h01, a); send_byte(8'h02, a); send_byte(8'h03, a);
    chk("R7 third byte ack", {31'd0, a}, 32'd1);
    send_byte(8'h04, a);
    chk("R8 fourth byte nack", {31'd0, a}, 32'd0);
    send_byte(8'h05, a);
    chk("R8 fifth byte nack", {31'd0, a}, 32'd0);
    i2c_stop(); q();
    chk("R8 single strobe", strobes - s0, 32'd1);
    chk("R8 word kept", {8'd0, word}, 32'h010203);

    s0 = strobes;
    i2c_start();
    send_byte(8'h20, a);
    send_byte(8'h77, a); send_byte(8'h66, a);
    i2c_stop(); q();
    chk("R9 no strobe after early stop", strobes - s0, 32'd0);
    chk("R9 word unchanged", {8'd0, word}, 32'h010203);

    s0 = strobes;
    i2c_start();
    send_byte(8'h20, a);
    send_byte(8'h99, a); send_byte(8'h88, a);
    i2c_start();
    send_byte(8'hE6, a);
    chk("R10 broadcast after repeated start", {31'd0, a}, 32'd1);
    send_byte(8'h0A, a); send_byte(8'h0B, a); send_byte(8'h0C, a);
    chk("R10 third byte after restart acked", {31'd0, a}, 32'd1);
    i2c_stop(); q();
    chk("R10 one strobe", strobes - s0, 32'd1);
    chk("R10 new word", {8'd0, last_word}, 32'h0A0B0C);

    s0 = strobes;
    i2c_start();
    send_byte(8'h20, a);
    send_byte(8'h44, a);
    i2c_start();
    send_byte(8'h22, a);
    chk("R10 mismatch after restart nack", {31'd0, a}, 32'd0);
    send_byte(8'h01, a);
    chk("R6 byte after mismatch nack", {31'd0, a}, 32'd0);
    i2c_stop(); q();
    chk("R10 no strobe", strobes - s0, 32'd0);
    chk("R7 strobe width one cycle", wide, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule